// File: doc/BRIEF.md
# Configurable-Trigger Interrupt Aggregator

This block gathers sixty-four external interrupt lines, grouped into two banks of thirty-two, and merges them into a single request toward a parent interrupt controller. Each line passes through a two-flop synchroniser. It is then judged by its own 2-bit trigger setting: a level setting (high or low active) reports the line's present state, and an edge setting (rising or falling) catches the edge and keeps it until software wipes it. A per-line mask keeps a line out of the merged request but leaves its status visible.

Software reaches the block through a plain 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for the address presented. There is no stream traffic, so the port has no valid/ready pair. A write always lands at the next clock edge and reads never stall. To change a line's trigger, software reads the type word, rewrites the 2-bit field, writes it back, and then sets and releases the line's clear bit so detection restarts from a clean state.

Top module: `intc_agg`

## Requirements
- R1: After synchronous reset, every mask bit is 1, every trigger field is 0, every clear bit is 0, every status bit is 0 while inputs are low, and `irq_o` is 0.
- R2: Source n belongs to bank n/32 at bit n%32. Bank b's registers sit at b×0x20 plus a local offset: type words at 0x04 and 0x08, clear at 0x10, mask at 0x14 and status at 0x1C.
- R3: A trigger field is 2 bits wide. Bits 0–15 of a bank use the type word at 0x04 and bits 16–31 use the word at 0x08. The field starts at bit 2×(bit mod 16). The codes are 0 = level high, 1 = level low, 2 = rising edge and 3 = falling edge.
- R4: A level-typed source shows status 1 exactly while its synchronised input is at the active level. The status follows an input change two clock edges later and is never latched.
- R5: An edge-typed source sets its status on the selected edge of the synchronised input, three edges after the raw input moves. It then holds the status until cleared, whatever the input does.
- R6: While a source's clear bit is 1, its status reads 0, its latched edge is wiped and edges are ignored. After the bit is written back to 0, a steady input raises no status.
- R7: A mask bit of 1 keeps that source out of `irq_o` but leaves its status bit readable. With every mask bit set, `irq_o` is 0 one edge later.
- R8: `irq_o` is the registered OR over both banks of status AND NOT mask. It reflects the status one clock edge later.
- R9: The type, clear and mask registers read back what was written. Status is read-only. Any other offset, and any address beyond the last bank, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 64 | Raw asynchronous interrupt lines, bit n is source n |
| bus_we | input | 1 | Write strobe, write lands at the next edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Merged interrupt request toward the parent controller |

## Verification
A register write takes effect at the edge that samples it and can be read back right after. A level status changes two edges after the raw input. An edge status appears three edges after it, and `irq_o` follows any status change by one more edge. The bench drives every input on the falling clock edge and steps a behavioural model on the rising edge, in the same order as the register stages listed above. It compares `irq_o` and register reads at the next falling edge, so each result is checked in exactly the cycle it is due. Directed phases cover each trigger code, clear, mask and unmapped addresses, and a random phase mixes input toggles with register writes.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    TRG_HI   = 2'd0,
    TRG_LO   = 2'd1,
    TRG_RISE = 2'd2,
    TRG_FALL = 2'd3
  } trig_e;

  localparam int OFF_TYP0 = 'h04;
  localparam int OFF_TYP1 = 'h08;
  localparam int OFF_CLR  = 'h10;
  localparam int OFF_MSK  = 'h14;
  localparam int OFF_STAT = 'h1C;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] s_i,
  input  logic [1:0]   we_typ,
  input  logic         we_clr,
  input  logic         we_msk,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] typ0_o,
  output logic [N-1:0] typ1_o,
  output logic [N-1:0] clr_o,
  output logic [N-1:0] msk_o,
  output logic [N-1:0] st_o
);
  localparam int HALF = N / 2;

  logic [N-1:0] pend_q;
  logic [N-1:0] prev_q;
  logic [N-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_o <= '0;
      msk_o <= '1;
    end else begin
      if (we_clr) clr_o <= wdata;
      if (we_msk) msk_o <= wdata;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    localparam int W = i / HALF;
    localparam int K = i % HALF;
    trig_e typ_q;

    always_ff @(posedge clk) begin
      if (rst) typ_q <= TRG_HI;
      else if (we_typ[W]) typ_q <= trig_e'(wdata[2*K +: 2]);
    end

    if (W == 0) begin : g_w0
      assign typ0_o[2*K +: 2] = typ_q;
    end else begin : g_w1
      assign typ1_o[2*K +: 2] = typ_q;
    end

    assign hit[i] = ((typ_q == TRG_RISE) &&  s_i[i] && !prev_q[i]) ||
                    ((typ_q == TRG_FALL) && !s_i[i] &&  prev_q[i]);

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= s_i[i];
        if (clr_o[i]) pend_q[i] <= 1'b0;
        else if (hit[i]) pend_q[i] <= 1'b1;
      end
    end

    always_comb begin
      if (clr_o[i])     st_o[i] = 1'b0;
      else if (typ_q[1]) st_o[i] = pend_q[i];
      else              st_o[i] = s_i[i] ^ (typ_q == TRG_LO);
    end

    // R5: a latched edge survives until a clear
    a_r5_edge_hold: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_o[i]) |=> pend_q[i]);

    // R6: a held clear wipes the latched edge
    a_r6_clr_wipe: assert property (@(posedge clk) disable iff (rst)
      clr_o[i] |=> !pend_q[i]);
  end
endmodule

// File: rtl/intc_agg.sv
module intc_agg
  import intc_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int NPB    = 32,
  parameter int AW     = 8,
  parameter int STRIDE = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NBANK*NPB-1:0]   src_i,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [NPB-1:0]         bus_wdata,
  output logic [NPB-1:0]         bus_rdata,
  output logic                   irq_o
);
  localparam int NSRC = NBANK * NPB;
  localparam int OFFW = $clog2(STRIDE);
  localparam int SELW = AW - OFFW;

  logic [NSRC-1:0] s_sync;
  logic [SELW-1:0] sel;
  logic [OFFW-1:0] off;
  logic [NPB-1:0]  typ0 [NBANK];
  logic [NPB-1:0]  typ1 [NBANK];
  logic [NPB-1:0]  clr  [NBANK];
  logic [NPB-1:0]  msk  [NBANK];
  logic [NPB-1:0]  st   [NBANK];
  logic            any_req;

  assign sel = bus_addr[AW-1:OFFW];
  assign off = bus_addr[OFFW-1:0];

  intc_sync #(.W(NSRC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (s_sync)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_b;
    assign hit_b = bus_we && (sel == SELW'(b));

    intc_bank #(.N(NPB)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .s_i    (s_sync[b*NPB +: NPB]),
      .we_typ ({hit_b && (off == OFFW'(OFF_TYP1)), hit_b && (off == OFFW'(OFF_TYP0))}),
      .we_clr (hit_b && (off == OFFW'(OFF_CLR))),
      .we_msk (hit_b && (off == OFFW'(OFF_MSK))),
      .wdata  (bus_wdata),
      .typ0_o (typ0[b]),
      .typ1_o (typ1[b]),
      .clr_o  (clr[b]),
      .msk_o  (msk[b]),
      .st_o   (st[b])
    );
  end

  always_comb begin
    bus_rdata = '0;
    any_req   = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      any_req = any_req | (|(st[b] & ~msk[b]));
      if (sel == SELW'(b)) begin
        case (int'(off))
          OFF_TYP0: bus_rdata = typ0[b];
          OFF_TYP1: bus_rdata = typ1[b];
          OFF_CLR:  bus_rdata = clr[b];
          OFF_MSK:  bus_rdata = msk[b];
          OFF_STAT: bus_rdata = st[b];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= any_req;
  end

  // R1: reset leaves the request low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !irq_o);

  // R7: with bank 0 fully masked and bank 1 fully masked, no request
  a_r7_all_masked: assert property (@(posedge clk) disable iff (rst)
    ((&msk[0]) && (&msk[NBANK-1])) |=> !irq_o);
endmodule

// File: tb/sim_intc_agg.sv
`timescale 1ns/1ps
module sim_intc_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intc_agg u0 (
    .clk(clk), .rst(rst), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit [63:0] m_f1, m_s, m_prev, m_pend, m_clr, m_msk;
  int        m_typ [64];
  bit        m_irq, nreq;

  function automatic bit mstat(int i);
    if (m_clr[i]) return 1'b0;
    if (m_typ[i] >= 2) return m_pend[i];
    return (m_typ[i] == 0) ? m_s[i] : !m_s[i];
  endfunction

  function automatic logic [31:0] mread(logic [7:0] a);
    int bk = a / 32;
    int of = a % 32;
    logic [31:0] v = '0;
    if (bk > 1) return '0;
    case (of)
      'h04: for (int k = 0; k < 16; k++) v[2*k +: 2] = m_typ[bk*32+k][1:0];
      'h08: for (int k = 0; k < 16; k++) v[2*k +: 2] = m_typ[bk*32+16+k][1:0];
      'h10: v = m_clr[bk*32 +: 32];
      'h14: v = m_msk[bk*32 +: 32];
      'h1C: for (int k = 0; k < 32; k++) v[k] = mstat(bk*32+k);
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_f1 = '0; m_s = '0; m_prev = '0; m_pend = '0; m_clr = '0; m_msk = '1;
      for (int i = 0; i < 64; i++) m_typ[i] = 0;
      m_irq = 1'b0;
    end else begin
      nreq = 1'b0;
      for (int i = 0; i < 64; i++) if (mstat(i) && !m_msk[i]) nreq = 1'b1;
      for (int i = 0; i < 64; i++) begin
        if (m_clr[i]) m_pend[i] = 1'b0;
        else if ((m_typ[i] == 2 && m_s[i] && !m_prev[i]) ||
                 (m_typ[i] == 3 && !m_s[i] && m_prev[i])) m_pend[i] = 1'b1;
        m_prev[i] = m_s[i];
        m_s[i]    = m_f1[i];
        m_f1[i]   = src[i];
      end
      m_irq = nreq;
      if (we && addr < 8'h40) begin
        case (addr % 32)
          'h04: for (int k = 0; k < 16; k++) m_typ[(addr/32)*32+k] = int'(wdata[2*k +: 2]);
          'h08: for (int k = 0; k < 16; k++) m_typ[(addr/32)*32+16+k] = int'(wdata[2*k +: 2]);
          'h10: m_clr[(addr/32)*32 +: 32] = wdata;
          'h14: m_msk[(addr/32)*32 +: 32] = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8: irq_o compared to the model on every cycle
  always @(negedge clk) if (!rst && !done) chk(irq === m_irq, "R8 irq_o", 32'(irq), 32'(m_irq));

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk); addr = a; #1;
    chk(rdata === exp && exp === mread(a), req, rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    rd(8'h14, 32'hFFFF_FFFF, "R1 mask bank0");
    rd(8'h34, 32'hFFFF_FFFF, "R1 mask bank1");
    rd(8'h24, 32'h0, "R1 type bank1");
    rd(8'h10, 32'h0, "R1 clear bank0");
    rd(8'h1C, 32'h0, "R1 status bank0");
    chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
    wr(8'h14, 32'h0);
    wr(8'h34, 32'h0);
    // R4: level high on source 5, two edges to status
    @(negedge clk); src[5] = 1'b1;
    @(negedge clk); addr = 8'h1C; #1; chk(rdata[5] === 1'b0, "R4 latency one edge", rdata, 0);
    @(negedge clk); #1; chk(rdata === 32'h20, "R4 level high visible", rdata, 32'h20);
    src[5] = 1'b0; idle(2); #1;
    chk(rdata === 32'h0, "R4 level not latched", rdata, 0);
    // R2/R3: source 40 = bank1 bit8, level low, field at 0x24 bits 17:16
    wr(8'h24, 32'h0001_0000);
    rd(8'h24, 32'h0001_0000, "R3 type readback");
    rd(8'h3C, 32'h0000_0100, "R2 R3 level low bank1 bit8");
    src[40] = 1'b1; idle(2);
    rd(8'h3C, 32'h0, "R3 level low inactive");
    // R5: source 20 rising, word 0x08 bits 9:8
    wr(8'h08, 32'h0000_0200);
    @(negedge clk); src[20] = 1'b1;
    @(negedge clk); src[20] = 1'b0;
    idle(3);
    rd(8'h1C, 32'h0010_0000, "R5 rising held");
    // R6: clear wipes it
    wr(8'h10, 32'h0010_0000);
    rd(8'h1C, 32'h0, "R6 status zero during clear");
    src[20] = 1'b1; idle(4);
    rd(8'h1C, 32'h0, "R6 edge ignored during clear");
    wr(8'h10, 32'h0);
    idle(3);
    rd(8'h1C, 32'h0, "R6 no status after release");
    src[20] = 1'b0;
    // R5: source 63 falling, word 0x28 bits 31:30
    wr(8'h28, 32'hC000_0000);
    src[63] = 1'b1; idle(4);
    rd(8'h3C, 32'h0, "R5 no status on rising for falling type");
    src[63] = 1'b0; idle(4);
    rd(8'h3C, 32'h8000_0000, "R5 falling latched");
    // R7: mask blocks irq, status stays
    wr(8'h34, 32'hFFFF_FFFF);
    idle(2);
    chk(irq === 1'b0, "R7 masked irq low", 32'(irq), 0);
    rd(8'h3C, 32'h8000_0000, "R7 status still visible");
    wr(8'h34, 32'h0);
    idle(2);
    chk(irq === 1'b1, "R7 unmasked irq high", 32'(irq), 1);
    // R9: unmapped and status writes ignored
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h0);
    rd(8'h0C, 32'h0, "R9 unmapped 0x0C");
    rd(8'h00, 32'h0, "R9 unmapped 0x00");
    rd(8'h44, 32'h0, "R9 beyond last bank");
    rd(8'h3C, 32'h8000_0000, "R9 status read-only");
    rd(8'h14, 32'h0, "R9 mask readback");
    // random phase: the model is compared each cycle
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      src = {$urandom, $urandom};
      we = ($urandom % 4) == 0;
      case ($urandom % 6)
        0: addr = 8'h04; 1: addr = 8'h28; 2: addr = 8'h10;
        3: addr = 8'h34; 4: addr = 8'h1C; default: addr = 8'h3C;
      endcase
      wdata = $urandom;
      if (addr[3:0] == 4'h0) wdata = wdata & 32'h0F0F_0F0F;
      #1;
      chk(rdata === mread(addr), "R4 R5 R6 random read", rdata, mread(addr));
    end
    @(negedge clk); we = 1'b0;
    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule